// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit register (width set by a parameter) whose parallel data lines form one shared, bidirectional bus. A two-bit function select picks one of four operations on each rising clock edge: keep the contents, shift toward the high-index bit, shift toward the low-index bit, or capture a parallel word from the bus. Two active-low output controls decide whether the register drives its contents back onto the same bus. Choosing the capture operation always releases the bus, so that an external source can drive the lines.

The tri-state bus is split into three signals: an input word, an output word and a drive-enable flag. A pad ring or wrapper joins them into real bidirectional pins. A serial input and a serial output sit at each end of the register. Linking the high-end serial output of one register to the low-end serial input of the next, and the reverse, chains several registers into a longer word. The clear is synchronous and active low.

Top module: `bidir_shift_reg`

## Requirements
- R1: With function select `fsel` = 2'b00 and `clr_n` high, the stored word is unchanged across rising clock edges.
- R2: With `fsel` = 2'b01, each rising edge moves every bit one place toward the high index, and `ser_up_in` enters bit 0.
- R3: With `fsel` = 2'b10, each rising edge moves every bit one place toward the low index, and `ser_dn_in` enters the top bit.
- R4: With `fsel` = 2'b11, the word on `bus_in` is stored on the rising edge.
- R5: A low `clr_n` zeroes every bit on the next rising edge, whatever the function select.
- R6: `bus_drive` is high only while `oe_a_n` and `oe_b_n` are both low and `fsel` is not 2'b11. While `fsel` is 2'b11 it is low.
- R7: While `bus_drive` is high, `bus_out` equals the stored word. While it is low, `bus_out` is all zeros.
- R8: `ser_out_lo` always shows bit 0 and `ser_out_hi` always shows the top bit, whatever the output controls.
- R9: Two registers joined through their serial pins, with shared controls, behave as one register of twice the width when shifting in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous clear, active low |
| fsel | input | 2 | Function select: 00 keep, 01 shift up, 10 shift down, 11 capture |
| oe_a_n | input | 1 | Output control A, active low |
| oe_b_n | input | 1 | Output control B, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an up shift |
| ser_dn_in | input | 1 | Serial bit entering the top bit on a down shift |
| bus_in | input | WIDTH | Word sampled from the shared bus |
| bus_out | output | WIDTH | Word presented to the shared bus |
| bus_drive | output | 1 | High when the bus drivers are on |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Top bit of the register |

## Verification
Two actions can fall on the same edge: a clear and any other operation, and a capture together with enabled output controls. The bench drives `clr_n` low while `fsel` selects capture with an all-ones bus, and again during a shift. It expects a zero word, which it then reads back through the bus. It also holds both output controls low during a capture and expects the drivers released for that cycle, with the captured word on the bus in the following keep cycle.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_CAPT = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_core.sv
module usr_core #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  usr_pkg::mode_e    mode,
  input  logic              ser_up_in,
  input  logic              ser_dn_in,
  input  logic [WIDTH-1:0]  load_val,
  output logic [WIDTH-1:0]  q
);
  import usr_pkg::*;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] up_val, dn_val, nxt;

  // neighbour selection for both shift directions, one bit per slice
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lo
      assign up_val[i] = ser_up_in;
    end else begin : g_lo_n
      assign up_val[i] = q[i-1];
    end
    if (i == MSB) begin : g_hi
      assign dn_val[i] = ser_dn_in;
    end else begin : g_hi_n
      assign dn_val[i] = q[i+1];
    end
  end

  always_comb begin
    unique case (mode)
      MODE_UP:   nxt = up_val;
      MODE_DOWN: nxt = dn_val;
      MODE_CAPT: nxt = load_val;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  // assertion support: becomes true after the first clear
  logic clr_seen = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) clr_seen <= 1'b1;
  end

  p_clear_r5: assert property (@(posedge clk) !clr_n |=> (q == '0));
  p_keep_r1: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && mode == MODE_KEEP) |=> (q == $past(q)));
  p_up_r2: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && mode == MODE_UP) |=> (q[0] == $past(ser_up_in) && q[MSB:1] == $past(q[MSB-1:0])));
  p_down_r3: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && mode == MODE_DOWN) |=> (q[MSB] == $past(ser_dn_in) && q[MSB-1:0] == $past(q[MSB:1])));
  p_capt_r4: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && mode == MODE_CAPT) |=> (q == $past(load_val)));
endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl #(
  parameter int WIDTH = 8
) (
  input  usr_pkg::mode_e    mode,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  input  logic [WIDTH-1:0]  q,
  output logic              drive,
  output logic [WIDTH-1:0]  bus_out
);
  import usr_pkg::*;
  logic oe_ok;

  assign oe_ok   = ~oe_a_n & ~oe_b_n;
  // a capture always frees the bus for the external source
  assign drive   = oe_ok & (mode != MODE_CAPT);
  assign bus_out = drive ? q : '0;
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [1:0]        fsel,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  input  logic              ser_up_in,
  input  logic              ser_dn_in,
  input  logic [WIDTH-1:0]  bus_in,
  output logic [WIDTH-1:0]  bus_out,
  output logic              bus_drive,
  output logic              ser_out_lo,
  output logic              ser_out_hi
);
  import usr_pkg::*;
  localparam int MSB = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] q;

  assign mode = mode_e'(fsel);

  usr_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode      (mode),
    .ser_up_in (ser_up_in),
    .ser_dn_in (ser_dn_in),
    .load_val  (bus_in),
    .q         (q)
  );

  usr_bus_ctrl #(.WIDTH(WIDTH)) u_bus (
    .mode    (mode),
    .oe_a_n  (oe_a_n),
    .oe_b_n  (oe_b_n),
    .q       (q),
    .drive   (bus_drive),
    .bus_out (bus_out)
  );

  // serial taps ignore the output controls so chains keep working
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  p_release_r6: assert property (@(posedge clk) disable iff (!armed)
    (fsel == 2'b11) |-> !bus_drive);
  p_oe_off_r6: assert property (@(posedge clk) disable iff (!armed)
    (oe_a_n || oe_b_n) |-> !bus_drive);
  p_show_r7: assert property (@(posedge clk) disable iff (!armed)
    bus_drive |-> (bus_out == q));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!armed)
    !bus_drive |-> (bus_out == '0));
endmodule

// File: tb/sim_bidir_shift_reg.sv
module sim_bidir_shift_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         clr_n = 1'b0;
  logic [1:0]   fsel = 2'b11;
  logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic         sin_up = 1'b0, sin_dn = 1'b0;
  logic [W-1:0] bin = '0;

  logic [W-1:0] bo0, bo1;
  logic         drv0, drv1, lo0, hi0, lo1, hi1;

  bidir_shift_reg #(.WIDTH(W)) u0 (
    .clk(clk), .clr_n(clr_n), .fsel(fsel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_up_in(sin_up), .ser_dn_in(lo1), .bus_in(bin),
    .bus_out(bo0), .bus_drive(drv0), .ser_out_lo(lo0), .ser_out_hi(hi0)
  );

  bidir_shift_reg #(.WIDTH(W)) u1 (
    .clk(clk), .clr_n(clr_n), .fsel(fsel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_up_in(hi0), .ser_dn_in(sin_dn), .bus_in(bin ^ 8'hA5),
    .bus_out(bo1), .bus_drive(drv1), .ser_out_lo(lo1), .ser_out_hi(hi1)
  );

  typedef struct {
    logic [W-1:0] b0, b1;
    logic         d, lo, hi;
    string        tag;
  } exp_t;

  exp_t           sb[$];
  logic [2*W-1:0] model = '0;
  int             checks = 0, errors = 0;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, then queue what the outputs must show
  task automatic step(input logic [1:0] f, input logic c_n, input logic a_n, input logic b_n,
                      input logic su, input logic sd, input logic [W-1:0] bi, input string tag);
    exp_t e;
    @(negedge clk);
    fsel = f; clr_n = c_n; oe_a_n = a_n; oe_b_n = b_n; sin_up = su; sin_dn = sd; bin = bi;
    @(posedge clk);
    if (!c_n) model = '0;
    else begin
      case (f)
        2'b01: model = {model[2*W-2:0], su};
        2'b10: model = {sd, model[2*W-1:1]};
        2'b11: model = {bi ^ 8'hA5, bi};
        default: model = model;
      endcase
    end
    e.d   = !a_n && !b_n && (f != 2'b11);
    e.b0  = e.d ? model[W-1:0] : '0;
    e.b1  = e.d ? model[2*W-1:W] : '0;
    e.lo  = model[0];
    e.hi  = model[W-1];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after the edge, before the next stimulus change
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "drive", {7'd0, drv0}, {7'd0, e.d});
      chk(e.tag, "bus_out", bo0, e.b0);
      chk(e.tag, "bus_out_chained", bo1, e.b1);
      chk(e.tag, "ser_lo", {7'd0, lo0}, {7'd0, e.lo});
      chk(e.tag, "ser_hi", {7'd0, hi0}, {7'd0, e.hi});
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R5: clear wins over capture of an all-ones bus
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, "R5");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
    // R4/R6: capture with outputs enabled releases the bus
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, "R4");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, "R1");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R1");
    // R2: up shifts
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R2");
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R2");
    // R3/R8: down shifts with the bus off, serial taps still live
    step(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R8");
    step(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
    step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
    step(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R3");
    // R6: each control alone disables the drivers
    step(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
    // R9: chained word moves across both registers
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, "R4");
    for (int i = 0; i < 10; i++)
      step(2'b01, 1'b1, 1'b0, 1'b0, i[0], 1'b0, 8'h00, "R9");
    for (int i = 0; i < 12; i++)
      step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, i[1], 8'h00, "R9");
    // R5: clear during a shift, then read back zero
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R5");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE7, "R4");
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5");
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R1");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule